// File: doc/BRIEF.md
# Ping-pong receive DMA sequencer

This block moves received frames into memory through two alternating descriptor sets. Each set holds a base address, a remaining-slot count and a command word, and covers a ring of fixed-size buffer slots. Every frame starts at the beginning of the next free slot of the active set. Its bytes go out through a simple memory write port that carries an address, a data byte and a write strobe. When a frame ends, the set's count goes down by one and a completion flag raises the interrupt. When a set runs out of slots it disarms itself and the engine moves to the other set. Software then reloads the spent set while the other one is in use.

Software reaches the block through a small register window. It can stop a set and read the set's remaining count, re-arm the set, or reload its base and count. A control word reports completion, overrun, the active set, the armed state of each set, a hold state and a fatal error. The error is raised when a frame overflows its slot, and it needs a full reset sequence to clear.

Top module: `rx_pingpong_dma`

## Requirements
- R1: After reset, the control word reads 0, both sets are disarmed, `irq` is 0 and `mem_we` is 0.
- R2: The host word address bit 2 selects the set (a byte offset of 0x10). Bits 1:0 select the register: 0 is the command, 1 is the base, 2 is the remaining count and 3 is the shared control word. The base and command read back as written.
- R3: Command 0x9800 arms a set. Commands 0x1100 (stop) and 0x0100 (load) disarm it. A stopped set keeps its count readable and unchanged, and it is re-armed by writing 0x9800 again.
- R4: Byte k of an accepted frame is written to base + s*0x800 + k, where s = 8 - remaining count when the frame starts. The `mem_we`/`mem_addr`/`mem_data` outputs appear one cycle after the byte is presented. A frame of exactly 0x800 bytes fills its slot completely.
- R5: The end of an accepted frame decrements the count of its set. It also sets control bit 8 (completion), which drives `irq`.
- R6: When a count reaches 0, that set disarms (control bit 2 for set 0, bit 3 for set 1) and the active set (control bit 4) switches to the other set. The next frame goes to that set's slot.
- R7: If a frame starts while the active set is disarmed or has a count of 0, nothing is written and control bit 0 (overrun) is set.
- R8: A byte beyond offset 0x7FF of a slot is not written. It sets control bit 13 (error), which drives `irq`. The frame's count is not decremented, and later frames are ignored without writes or overrun until the reset sequence.
- R9: Writing 0x8800 to control disarms both sets, clears the error, completion and overrun flags, selects set 0 and enters hold (control bit 1). In hold, frames are ignored. Writing 0x0400 leaves hold.
- R10: Any other control write clears bit 8 and bit 0 where the written value has a 1 and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host word address: [2] set, [1:0] register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from host_addr) |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Receive byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 8 | Memory write byte |
| irq | output | 1 | Completion or error interrupt |

## Verification
The assertions assume a few things about the inputs:
- `rx_sof` and `rx_eof` only count when `rx_valid` is high.
- A frame's last byte never coincides with a host write to the count or command of the set that frame is using.
- The host does not change the active set except through the 0x8800 control code.

The stimulus keeps to these. It performs every register write only while the receive side is idle, and it drives each frame as one unbroken run of valid bytes with start and end markers on the first and last bytes.

// File: rtl/rx_pingpong_dma.sv
module rx_pingpong_dma #(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 2048,
  parameter int AW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [2:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [7:0]    rx_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          irq
);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SB_W   = $clog2(SLOT_BYTES);
  localparam int OFF_W  = SB_W + 1;
  localparam logic [15:0] CMD_ARM  = 16'h9800;
  localparam logic [15:0] CMD_STOP = 16'h1100;
  localparam logic [15:0] CMD_LOAD = 16'h0100;
  localparam logic [31:0] CTL_HOLD = 32'h0000_8800;
  localparam logic [31:0] CTL_GO   = 32'h0000_0400;

  logic [AW-1:0]    base_q  [2];
  logic [CNT_W-1:0] cnt_q   [2];
  logic [15:0]      cmd_q   [2];
  logic [1:0]       armed_q;
  logic             act_q, hold_q, err_q, done_q, ovr_q;
  logic             in_frame, f_set;
  logic [SLOT_W-1:0] f_slot;
  logic [OFF_W-1:0]  f_off;

  wire h_set = host_addr[2];
  wire [1:0] h_reg = host_addr[1:0];

  wire start      = rx_valid && rx_sof && !in_frame;
  wire eng_on     = !hold_q && !err_q;
  wire act_ok     = armed_q[act_q] && (cnt_q[act_q] != '0);
  wire take_start = start && eng_on && act_ok;
  wire drop_start = start && eng_on && !act_ok;
  wire in_byte    = in_frame && rx_valid;
  wire byte_any   = take_start || in_byte;

  logic              b_set;
  logic [SLOT_W-1:0] b_slot;
  logic [OFF_W-1:0]  b_off;
  always_comb begin
    if (in_frame) begin
      b_set  = f_set;
      b_slot = f_slot;
      b_off  = f_off;
    end else begin
      b_set  = act_q;
      b_slot = SLOT_W'(SLOTS - int'(cnt_q[act_q]));
      b_off  = '0;
    end
  end

  wire b_ovf   = b_off[SB_W];
  wire b_write = byte_any && !b_ovf;
  wire finish  = byte_any && rx_eof && !b_ovf;
  wire [AW-1:0] b_addr = base_q[b_set] + (AW'(b_slot) << SB_W) + AW'(b_off[SB_W-1:0]);

  logic [31:0] stat;
  always_comb begin
    stat     = '0;
    stat[13] = err_q;
    stat[8]  = done_q;
    stat[4]  = act_q;
    stat[3]  = armed_q[1];
    stat[2]  = armed_q[0];
    stat[1]  = hold_q;
    stat[0]  = ovr_q;
  end

  always_comb begin
    case (h_reg)
      2'd0:    host_rdata = {16'h0, cmd_q[h_set]};
      2'd1:    host_rdata = 32'(base_q[h_set]);
      2'd2:    host_rdata = 32'(cnt_q[h_set]);
      default: host_rdata = stat;
    endcase
  end

  assign irq = done_q || err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        base_q[i] <= '0;
        cnt_q[i]  <= '0;
        cmd_q[i]  <= '0;
      end
      armed_q  <= '0;
      act_q    <= 1'b0;
      hold_q   <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      in_frame <= 1'b0;
      f_set    <= 1'b0;
      f_slot   <= '0;
      f_off    <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= b_write;
      if (b_write) begin
        mem_addr <= b_addr;
        mem_data <= rx_data;
      end
      if (take_start) begin
        in_frame <= !rx_eof;
        f_set    <= act_q;
        f_slot   <= b_slot;
        f_off    <= OFF_W'(1);
      end else if (in_byte) begin
        if (rx_eof) in_frame <= 1'b0;
        if (!b_ovf) f_off <= f_off + OFF_W'(1);
        else        err_q <= 1'b1;
      end
      if (drop_start) ovr_q <= 1'b1;
      if (finish) begin
        done_q <= 1'b1;
        cnt_q[b_set] <= cnt_q[b_set] - CNT_W'(1);
        if (cnt_q[b_set] == CNT_W'(1)) begin
          armed_q[b_set] <= 1'b0;
          act_q <= ~b_set;
        end
      end
      if (host_wr) begin
        case (h_reg)
          2'd0: begin
            cmd_q[h_set] <= host_wdata[15:0];
            if (host_wdata[15:0] == CMD_ARM) armed_q[h_set] <= 1'b1;
            else if (host_wdata[15:0] == CMD_STOP || host_wdata[15:0] == CMD_LOAD)
              armed_q[h_set] <= 1'b0;
          end
          2'd1: base_q[h_set] <= host_wdata[AW-1:0];
          2'd2: cnt_q[h_set]  <= host_wdata[CNT_W-1:0];
          default: begin
            if (host_wdata == CTL_HOLD) begin
              hold_q   <= 1'b1;
              err_q    <= 1'b0;
              done_q   <= 1'b0;
              ovr_q    <= 1'b0;
              armed_q  <= '0;
              act_q    <= 1'b0;
              in_frame <= 1'b0;
            end else if (host_wdata == CTL_GO) begin
              hold_q <= 1'b0;
            end else begin
              if (host_wdata[8]) done_q <= 1'b0;
              if (host_wdata[0]) ovr_q  <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assert_write_follows_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(rx_valid) && mem_data == $past(rx_data)));

  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_valid && rx_sof));

  assert_error_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(rx_valid) && !mem_we));

  assert_switch_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> ($past(rx_valid && rx_eof) || $past(host_wr)));

  assert_count_rise_by_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[0] > $past(cnt_q[0])) |-> $past(host_wr));

  assert_quiet_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q)) |-> !mem_we);
endmodule

// File: tb/rx_pingpong_dma_tb_top.sv
`timescale 1ns/1ps
module rx_pingpong_dma_tb_top;
  logic clk = 0, rst_n = 0, host_wr = 0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = '0, mem_data;
  logic mem_we, irq;
  logic [31:0] mem_addr;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_pingpong_dma dut_i (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq));

  localparam int NV = 10;
  localparam int          FR_LEN  [NV] = '{1, 5, 64, 3, 2048, 7, 2, 9, 4, 1};
  localparam logic [31:0] EXP_ADR [NV] = '{32'h1000_0000, 32'h1000_0800, 32'h1000_1000,
    32'h1000_1800, 32'h1000_2000, 32'h1000_2800, 32'h1000_3000, 32'h1000_3800,
    32'h2000_0000, 32'h2000_0800};
  localparam int          EXP_SET [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int          EXP_CNT [NV] = '{7, 6, 5, 4, 3, 2, 1, 0, 7, 6};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic send_frame(input int len, input int nwr, input logic [31:0] start,
                            input logic [7:0] seed, output int bad);
    bad = 0;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (mem_we !== ((i - 1) < nwr)) bad++;
        else if (mem_we && (mem_addr !== start + 32'(i - 1) || mem_data !== seed + 8'(i - 1))) bad++;
      end
      if (i < len) begin
        rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = seed + 8'(i);
      end else begin
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
      end
    end
  endtask

  task automatic setup_set(input logic s, input logic [31:0] base);
    wr({s, 2'd0}, 32'h0100);
    wr({s, 2'd1}, base);
    wr({s, 2'd2}, 32'd8);
    wr({s, 2'd0}, 32'h9800);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd3, v);
    chk(v == 0 && !irq && !mem_we, "R1 reset state", v, 0);

    wr(3'd3, 32'h8800);
    setup_set(0, 32'h1000_0000);
    setup_set(1, 32'h2000_0000);
    wr(3'd3, 32'h0400);
    rd(3'd5, v);
    chk(v == 32'h2000_0000, "R2 set1 base at offset", v, 32'h2000_0000);
    rd(3'd4, v);
    chk(v == 32'h9800, "R3 command readback", v, 32'h9800);
    rd(3'd3, v);
    chk(v == 32'h000C, "R3 both armed", v, 32'h000C);

    for (int i = 0; i < NV; i++) begin
      send_frame(FR_LEN[i], FR_LEN[i], EXP_ADR[i], 8'(i * 17), bad);
      chk(bad == 0, "R4 frame placement", 32'(bad), 0);
      rd({EXP_SET[i] != 0, 2'd2}, v);
      chk(v == 32'(EXP_CNT[i]), "R5 count decrement", v, 32'(EXP_CNT[i]));
      if (i == 7) begin
        rd(3'd3, v);
        chk(v[4] == 1 && v[2] == 0 && v[3] == 1, "R6 switch to set1", v, 32'h0118);
      end
    end
    rd(3'd3, v);
    chk(v[8] && irq, "R5 completion flag", v, 32'h0118);
    wr(3'd3, 32'h0100);
    rd(3'd3, v);
    chk(!v[8] && !irq && v[4], "R10 clear completion", v, 32'h0018);

    wr(3'd4, 32'h1100);
    rd(3'd6, v);
    chk(v == 6, "R3 stopped count readable", v, 6);
    send_frame(3, 0, 0, 8'h40, bad);
    chk(bad == 0, "R7 no writes on overrun", 32'(bad), 0);
    rd(3'd3, v);
    chk(v[0] == 1, "R7 overrun flag", v, 32'h0011);
    rd(3'd6, v);
    chk(v == 6, "R3 stopped count unchanged", v, 6);
    wr(3'd3, 32'h0001);
    rd(3'd3, v);
    chk(v == 32'h0010, "R10 clear overrun only", v, 32'h0010);

    wr(3'd4, 32'h9800);
    send_frame(6, 6, 32'h2000_1000, 8'h55, bad);
    chk(bad == 0, "R3 re-armed set accepts", 32'(bad), 0);

    setup_set(0, 32'h1000_0000);
    for (int k = 0; k < 5; k++) begin
      send_frame(2, 2, 32'h2000_1800 + 32'(k) * 32'h800, 8'(k), bad);
      chk(bad == 0, "R4 set1 later slots", 32'(bad), 0);
    end
    rd(3'd3, v);
    chk(v[4] == 0 && v[3] == 0 && v[2] == 1, "R6 back to set0", v, 32'h0104);
    send_frame(4, 4, 32'h1000_0000, 8'h90, bad);
    chk(bad == 0, "R6 next frame in set0 slot0", 32'(bad), 0);

    send_frame(2049, 2048, 32'h1000_0800, 8'h21, bad);
    chk(bad == 0, "R8 overflow byte dropped", 32'(bad), 0);
    rd(3'd3, v);
    chk(v[13] && irq, "R8 error flag", v, 32'h2104);
    rd(3'd2, v);
    chk(v == 7, "R8 count kept", v, 7);
    send_frame(3, 0, 0, 8'h33, bad);
    rd(3'd3, v);
    chk(bad == 0 && !v[0], "R8 frames ignored after error", v, 32'h2104);

    wr(3'd3, 32'h8800);
    rd(3'd3, v);
    chk(v == 32'h0002 && !irq, "R9 reset sequence state", v, 32'h0002);
    send_frame(2, 0, 0, 8'h11, bad);
    rd(3'd3, v);
    chk(bad == 0 && v == 32'h0002, "R9 hold ignores frames", v, 32'h0002);
    setup_set(0, 32'h3000_0000);
    wr(3'd3, 32'h0400);
    send_frame(3, 3, 32'h3000_0000, 8'h77, bad);
    rd(3'd3, v);
    chk(bad == 0 && !v[1], "R9 release after 0x0400", v, 32'h0104);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule